// File: doc/BRIEF.md
# Pipeline Performance Monitor

This block is a bank of performance counters that sits beside a frame-processing pipeline. It counts the clock cycles a frame takes, the pixels that are actually written, the texture cache misses, and the traffic at two valid/ready monitor points. At each monitor point every cycle falls into one of three classes: a stalled transaction, a completed transaction, or no transaction.

Software starts a frame with a one-cycle start command. That command clears every counter and marks the block busy. The pipeline reports that it has drained all of its output with a frame-end strobe. The block then leaves the busy state and raises a one-cycle done pulse, which serves as an edge-style interrupt. After that the counters can be read through a combinational read port addressed by byte offset. Counters hold their value between frames and saturate instead of wrapping.

Top module: `pipe_perf_mon`

## Requirements
- R1: A cycle with `start_i` high clears all seven counters to 0 and sets `busy_o` at the next edge. Start takes priority over `frame_end_i` in the same cycle.
- R2: When `frame_end_i` is high in a busy cycle without start, `busy_o` falls at the next edge and `done_o` is high for exactly that one following cycle.
- R3: The cycle counter increases by one for each clock cycle in which the block is busy and `start_i` is low.
- R4: The pixel counter increases by one for each busy cycle with `pix_wr_i` high and `pix_offscreen_i` low. Writes flagged off-screen are not counted.
- R5: At each monitor point m (0 or 1), a busy cycle with `mon_stb_i[m]`=1 and `mon_ack_i[m]`=0 increments that point's stalled counter.
- R6: At each monitor point m, a busy cycle with `mon_stb_i[m]`=1 and `mon_ack_i[m]`=1 increments that point's completed counter.
- R7: A cycle with `mon_stb_i[m]`=0 changes neither counter of point m, whatever the value of `mon_ack_i[m]`.
- R8: The miss counter increases by one for each busy cycle with `miss_i` high.
- R9: While the block is not busy, event inputs are ignored and every counter holds its value.
- R10: A counter that has reached 2^CNT_W-1 stays at that value until the next start.
- R11: The read port returns counters at byte offsets 0x34 (pixels), 0x38 (cycles), 0x3C (point 0 stalled), 0x40 (point 0 completed), 0x44 (point 1 stalled), 0x48 (point 1 completed) and 0x4C (misses), zero-extended to 32 bits. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start command: clears the counters and sets busy |
| frame_end_i | input | 1 | Pipeline has sent all output data for the frame |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pix_wr_i | input | 1 | Pixel write strobe |
| pix_offscreen_i | input | 1 | Current pixel write lies off-screen |
| mon_stb_i | input | 2 | Valid signal at each monitor point |
| mon_ack_i | input | 2 | Ready signal at each monitor point |
| miss_i | input | 1 | Texture cache miss strobe |
| rd_addr_i | input | 8 | Read byte offset |
| rd_data_o | output | 32 | Read data |

## Verification
The hardest condition to reach from the ports is saturation. With 32-bit counters it would take billions of busy cycles. The bench therefore builds the block with 8-bit counters and runs a frame longer than 255 cycles with the miss strobe held high. That drives the cycle and miss counters into their limits, and the frame then continues past them. The bench also applies start and frame-end in the same cycle, and sends stall, complete and ack-only patterns while the block is idle. This confirms that priority and idle masking hold at the counter level.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int NUM_CNT = 7;
  localparam int NUM_MON = 2;
  localparam int IDX_PIX = 0;
  localparam int IDX_CYC = 1;
  localparam int IDX_MON = 2;  // point m: stall at IDX_MON+2m, complete at +1
  localparam int IDX_MISS = 6;
  localparam logic [7:0] BASE_OFS = 8'h34;
endpackage

// File: rtl/pmon_counter.sv
module pmon_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_o <= '0;
    else if (clr_i)                   cnt_o <= '0;
    else if (inc_i && cnt_o != MAX)   cnt_o <= cnt_o + 1'b1;
  end

  p_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
  p_sat_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_o == MAX) |=> cnt_o == MAX);
  p_no_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_o != '0) |=> cnt_o != '0);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/pmon_classifier.sv
module pmon_classifier (
  input  logic stb_i,
  input  logic ack_i,
  output logic stall_o,
  output logic comp_o
);
  always_comb begin
    stall_o = stb_i & ~ack_i;
    comp_o  = stb_i & ack_i;
  end

  always_comb begin
    p_exclusive_r5: assert (!(stall_o && comp_o));
  end
endmodule

// File: rtl/pmon_ctrl.sv
module pmon_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic frame_end_i,
  output logic busy_o,
  output logic done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= busy_o & frame_end_i & ~start_i;
      if (start_i)          busy_o <= 1'b1;
      else if (frame_end_i) busy_o <= 1'b0;
    end
  end

  p_start_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: rtl/pipe_perf_mon.sv
module pipe_perf_mon
  import pmon_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int RD_W  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                frame_end_i,
  output logic                busy_o,
  output logic                done_o,
  input  logic                pix_wr_i,
  input  logic                pix_offscreen_i,
  input  logic [NUM_MON-1:0]  mon_stb_i,
  input  logic [NUM_MON-1:0]  mon_ack_i,
  input  logic                miss_i,
  input  logic [7:0]          rd_addr_i,
  output logic [RD_W-1:0]     rd_data_o
);
  logic [NUM_CNT-1:0] ev;
  logic [NUM_CNT-1:0] inc;
  logic [CNT_W-1:0]   cnt [NUM_CNT];
  logic               count_en;

  pmon_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .frame_end_i(frame_end_i),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  assign count_en     = busy_o & ~start_i;
  assign ev[IDX_PIX]  = pix_wr_i & ~pix_offscreen_i;
  assign ev[IDX_CYC]  = 1'b1;
  assign ev[IDX_MISS] = miss_i;

  for (genvar m = 0; m < NUM_MON; m++) begin : g_mon
    pmon_classifier u_cls (
      .stb_i  (mon_stb_i[m]),
      .ack_i  (mon_ack_i[m]),
      .stall_o(ev[IDX_MON+2*m]),
      .comp_o (ev[IDX_MON+2*m+1])
    );
  end

  assign inc = ev & {NUM_CNT{count_en}};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    pmon_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (start_i),
      .inc_i (inc[i]),
      .cnt_o (cnt[i])
    );
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (rd_addr_i == 8'(int'(BASE_OFS) + 4*i)) rd_data_o = RD_W'(cnt[i]);
  end

  p_idle_cyc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(cnt[IDX_CYC]));
  p_no_stb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mon_stb_i[0] && !start_i) |=> ($stable(cnt[IDX_MON]) && $stable(cnt[IDX_MON+1])));
  p_offscreen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_offscreen_i && !start_i) |=> $stable(cnt[IDX_PIX]));
  p_busy_cyc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en && cnt[IDX_CYC] == '0) |=> cnt[IDX_CYC] != '0);
endmodule

// File: tb/pipe_perf_mon_bench.sv
module pipe_perf_mon_bench;
  localparam int CW  = 8;
  localparam int MAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, fend = 0, pix_wr = 0, pix_off = 0, miss = 0;
  logic [1:0] stb = 0, ack = 0;
  logic [7:0] addr = 8'h34;
  logic busy, done;
  logic [31:0] rdata;

  always #5 clk = ~clk;

  pipe_perf_mon #(.CNT_W(CW), .RD_W(32)) u_pipe_perf_mon (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .frame_end_i(fend),
    .busy_o(busy), .done_o(done), .pix_wr_i(pix_wr), .pix_offscreen_i(pix_off),
    .mon_stb_i(stb), .mon_ack_i(ack), .miss_i(miss),
    .rd_addr_i(addr), .rd_data_o(rdata)
  );

  // reference model: 0 pix,1 cyc,2 m0 stall,3 m0 comp,4 m1 stall,5 m1 comp,6 miss
  int m_cnt [7];
  bit m_busy, m_done;
  int n_chk = 0, n_fail = 0;
  string tag_ovr = "";
  bit finished = 0;

  function automatic void bump(int i);
    if (m_cnt[i] < MAX) m_cnt[i]++;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_busy = 0; m_done = 0;
    end else begin
      m_done = m_busy && fend && !start;
      if (start) begin
        foreach (m_cnt[i]) m_cnt[i] = 0;
        m_busy = 1;
      end else if (m_busy) begin
        bump(1);
        if (pix_wr && !pix_off) bump(0);
        for (int m = 0; m < 2; m++) begin
          if (stb[m] && !ack[m]) bump(2 + 2*m);
          if (stb[m] && ack[m])  bump(3 + 2*m);
        end
        if (miss) bump(6);
        if (fend) m_busy = 0;
      end
    end
  end

  function automatic int exp_rd(logic [7:0] a);
    for (int i = 0; i < 7; i++) if (a == 8'(52 + 4*i)) return m_cnt[i];
    return 0;
  endfunction

  function automatic string rd_tag(logic [7:0] a);
    case (a)
      8'h34: return "R4";
      8'h38: return "R3";
      8'h3C, 8'h44: return "R5";
      8'h40, 8'h48: return "R6";
      8'h4C: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: sample after the edge, then compare against the model
  task automatic step();
    @(negedge clk);
    check("R2 busy", {31'd0, busy}, {31'd0, m_busy});
    check("R2 done", {31'd0, done}, {31'd0, m_done});
    check(tag_ovr != "" ? tag_ovr : rd_tag(addr), rdata, 32'(exp_rd(addr)));
  endtask

  task automatic quiet();
    start = 0; fend = 0; pix_wr = 0; pix_off = 0; miss = 0; stb = 0; ack = 0;
  endtask

  task automatic rand_ev();
    pix_wr = 1'($urandom); pix_off = 1'($urandom); miss = 1'($urandom);
    stb = 2'($urandom); ack = 2'($urandom);
    addr = 8'(52 + 4 * ($urandom % 8));
  endtask

  task automatic read_all(string req);
    tag_ovr = req;
    for (int i = 0; i < 8; i++) begin addr = 8'(52 + 4*i); step(); end
    tag_ovr = "";
  endtask

  task automatic frame(int len);
    start = 1; step(); start = 0;
    for (int c = 0; c < len; c++) begin rand_ev(); step(); end
    quiet(); fend = 1; step(); fend = 0; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    read_all("R1 reset");
    // start clears, immediate readback of pixels is zero
    frame(40);
    start = 1; step(); start = 0;
    addr = 8'h34; step();
    check("R1 cleared", rdata, 32'd0);
    quiet(); fend = 1; step(); fend = 0;
    // random frames of several lengths
    for (int f = 0; f < 6; f++) frame(20 + f * 30);
    // idle events ignored
    for (int c = 0; c < 50; c++) begin rand_ev(); step(); end
    quiet(); read_all("R9 idle");
    // stb low with ack toggling: R7
    start = 1; step(); start = 0;
    for (int c = 0; c < 40; c++) begin stb = 0; ack = 2'($urandom); step(); end
    quiet(); fend = 1; step(); fend = 0; step();
    addr = 8'h3C; step(); check("R7 m0 stall", rdata, 32'd0);
    addr = 8'h40; step(); check("R7 m0 comp", rdata, 32'd0);
    addr = 8'h48; step(); check("R7 m1 comp", rdata, 32'd0);
    // start and frame end together: start wins (R1)
    start = 1; step(); start = 1; fend = 1; step(); start = 0; fend = 0;
    step(); check("R1 start priority", {31'd0, busy}, 32'd1);
    quiet(); fend = 1; step(); fend = 0; step();
    // saturation: long frame with misses held high (R10)
    start = 1; step(); start = 0;
    for (int c = 0; c < 300; c++) begin miss = 1; addr = 8'h4C; step(); end
    quiet(); fend = 1; step(); fend = 0; step();
    addr = 8'h4C; step(); check("R10 miss sat", rdata, 32'(MAX));
    addr = 8'h38; step(); check("R10 cyc sat", rdata, 32'(MAX));
    // unmapped addresses (R11)
    addr = 8'h30; step(); check("R11 below", rdata, 32'd0);
    addr = 8'h36; step(); check("R11 unaligned", rdata, 32'd0);
    addr = 8'h50; step(); check("R11 above", rdata, 32'd0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule